// File: doc/BRIEF.md
# Level-Qualified Tone Class Output with Change Interrupt

This block sits behind a call-progress tone classifier. Each clock it takes three class flags (call-progress band present, narrow 620 Hz tone present, no usable signal) and a flag from a separate amplitude detector. It turns them into a registered four-line output word. The class lines carry meaning only while the amplitude detector reports enough signal. While the amplitude is too low they are held low. A configuration input can force the amplitude condition true, for designs that qualify amplitude elsewhere.

The output word is registered. Whenever the registered word takes a new value, a sticky interrupt line is raised so that a host can react to a change of tone class without polling. The host clears the interrupt with a one-cycle acknowledge pulse. A change that lands in the same cycle as the acknowledge wins, so no event is lost. The outputs are plain status lines that follow the inputs every cycle. They carry no handshake and no back-pressure: a consumer that is not looking simply sees the latest word.

Top module: `tone_out_gate`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it is asserted, `data_o`, `valid_o` and `irq_o` are all 0.
- R2: The effective level is `lvl_det_i | lvl_force_i`. On each clock edge it is captured into `data_o[3]`, and `valid_o` equals the captured value.
- R3: On each clock edge with the effective level true, `data_o[0]` takes `cp_det_i`, `data_o[1]` takes `tone620_det_i` and `data_o[2]` takes `nosig_det_i`.
- R4: On each clock edge with the effective level false, `data_o[2:0]` become 0 whatever the class flags are.
- R5: While `lvl_force_i` is 1, the word is captured as if the amplitude detector reported level present, even with `lvl_det_i` at 0.
- R6: When a clock edge (other than the first after reset) loads `data_o` with a value different from the one it held, `irq_o` is 1 after that same edge.
- R7: Once set, `irq_o` stays 1 until an edge where `irq_ack_i` is 1 and `data_o` does not change. After that edge `irq_o` is 0.
- R8: An edge where `irq_ack_i` is 1 and `data_o` changes leaves `irq_o` at 1.
- R9: The first clock edge after `rst` is released never sets `irq_o`, whatever value it loads into `data_o`.
- R10: While the effective level is false, changes on the class flags leave `data_o` unchanged and raise no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cp_det_i | input | 1 | Call-progress band detected |
| tone620_det_i | input | 1 | Narrow 620 Hz tone detected |
| nosig_det_i | input | 1 | No usable signal detected |
| lvl_det_i | input | 1 | Amplitude detector reports enough level |
| lvl_force_i | input | 1 | Configuration: treat level as always present |
| irq_ack_i | input | 1 | One-cycle interrupt acknowledge |
| data_o | output | 4 | Bit0 call-progress, bit1 620 Hz, bit2 no-signal, bit3 level present |
| valid_o | output | 1 | Registered effective level; word is meaningful when 1 |
| irq_o | output | 1 | Sticky interrupt raised on a change of `data_o` |

## Verification
The bench first loads a non-zero word on the first edge after reset. A design that compares against the reset value would raise a spurious interrupt there. It then drives an acknowledge in the same cycle as a class change, which catches a design that lets the clear beat the set and drops the event. It also toggles the class flags while level is absent and while force is asserted. A gate on the wrong bit or a force that is ignored would show up as class lines leaking through or staying dark. A long mixed stretch of flag, level and acknowledge patterns is compared cycle by cycle against a behavioural model, so a wrong bit position or a missed change is reported.

// File: rtl/tone_out_pkg.sv
package tone_out_pkg;
  localparam int CAT_W  = 3;
  localparam int WORD_W = CAT_W + 1;
  localparam int LVL_BIT = CAT_W;
  localparam int CP_BIT    = 0;
  localparam int T620_BIT  = 1;
  localparam int NOSIG_BIT = 2;
endpackage

// File: rtl/tone_lvl_gate.sv
module tone_lvl_gate
  import tone_out_pkg::*;
(
  input  logic [CAT_W-1:0]  cat_i,
  input  logic              lvl_det_i,
  input  logic              lvl_force_i,
  output logic [WORD_W-1:0] word_o
);
  logic lvl_eff;
  assign lvl_eff = lvl_det_i | lvl_force_i;

  for (genvar g = 0; g < CAT_W; g++) begin : g_cat
    assign word_o[g] = cat_i[g] & lvl_eff;
  end
  assign word_o[LVL_BIT] = lvl_eff;
endmodule

// File: rtl/tone_word_reg.sv
module tone_word_reg
  import tone_out_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_q,
  output logic              primed_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      word_q   <= word_i;
      primed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tone_chg_irq.sv
module tone_chg_irq
  import tone_out_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              primed_i,
  input  logic [WORD_W-1:0] next_i,
  input  logic [WORD_W-1:0] held_i,
  input  logic              ack_i,
  output logic              irq_o
);
  logic diff;
  assign diff = primed_i && (next_i != held_i);

  always_ff @(posedge clk) begin
    if (rst)        irq_o <= 1'b0;
    else if (diff)  irq_o <= 1'b1;
    else if (ack_i) irq_o <= 1'b0;
  end

  // R9
  first_edge_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !primed_i |=> !irq_o);
  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !ack_i) |=> irq_o);
endmodule

// File: rtl/tone_out_gate.sv
module tone_out_gate
  import tone_out_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cp_det_i,
  input  logic        tone620_det_i,
  input  logic        nosig_det_i,
  input  logic        lvl_det_i,
  input  logic        lvl_force_i,
  input  logic        irq_ack_i,
  output logic [3:0]  data_o,
  output logic        valid_o,
  output logic        irq_o
);
  logic [CAT_W-1:0]  cat;
  logic [WORD_W-1:0] gated;
  logic [WORD_W-1:0] held;
  logic              primed;

  assign cat[CP_BIT]    = cp_det_i;
  assign cat[T620_BIT]  = tone620_det_i;
  assign cat[NOSIG_BIT] = nosig_det_i;

  tone_lvl_gate u_gate (
    .cat_i       (cat),
    .lvl_det_i   (lvl_det_i),
    .lvl_force_i (lvl_force_i),
    .word_o      (gated)
  );

  tone_word_reg u_reg (
    .clk      (clk),
    .rst      (rst),
    .word_i   (gated),
    .word_q   (held),
    .primed_q (primed)
  );

  tone_chg_irq u_irq (
    .clk      (clk),
    .rst      (rst),
    .primed_i (primed),
    .next_i   (gated),
    .held_i   (held),
    .ack_i    (irq_ack_i),
    .irq_o    (irq_o)
  );

  assign data_o  = held;
  assign valid_o = held[LVL_BIT];

  // R4
  gate_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!lvl_det_i && !lvl_force_i) |=> (data_o[2:0] == 3'b000));
  // R5
  force_level_chk: assert property (@(posedge clk) disable iff (rst)
    lvl_force_i |=> valid_o);
  // R6
  rise_on_change_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> (data_o != $past(data_o)));
endmodule

// File: tb/tone_out_gate_tb.sv
module tone_out_gate_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cp = 0, t6 = 0, ns = 0, ld = 0, lf = 0, ak = 0;
  logic [3:0] data_o;
  logic valid_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [3:0] m_data;
  logic       m_irq;
  bit         m_primed;

  always #5 clk = ~clk;

  tone_out_gate u_dut (
    .clk(clk), .rst(rst), .cp_det_i(cp), .tone620_det_i(t6),
    .nosig_det_i(ns), .lvl_det_i(ld), .lvl_force_i(lf),
    .irq_ack_i(ak), .data_o(data_o), .valid_o(valid_o), .irq_o(irq_o)
  );

  task automatic model_edge();
    logic [3:0] nd;
    if (rst) begin
      m_data = 4'h0; m_irq = 1'b0; m_primed = 0;
    end else begin
      nd = (ld | lf) ? {1'b1, ns, t6, cp} : 4'h0;
      if (m_primed && nd != m_data) m_irq = 1'b1;
      else if (ak)                  m_irq = 1'b0;
      m_data = nd;
      m_primed = 1;
    end
  endtask

  task automatic compare(input string req);
    n_chk++;
    if (data_o !== m_data || valid_o !== m_data[3] || irq_o !== m_irq) begin
      n_bad++;
      $display("FAIL %s: data=%b valid=%b irq=%b expected data=%b valid=%b irq=%b",
               req, data_o, valid_o, irq_o, m_data, m_data[3], m_irq);
    end
  endtask

  task automatic step(input logic c, input logic t, input logic n,
                      input logic l, input logic f, input logic a,
                      input string req);
    cp = c; t6 = t; ns = n; ld = l; lf = f; ak = a;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    @(negedge clk);
    rst = 1'b1;
    step(1, 1, 1, 1, 1, 0, "R1");
    step(1, 0, 1, 1, 0, 1, "R1");
    rst = 1'b0;
    // R9: first edge loads a non-zero word, no interrupt
    step(1, 0, 0, 1, 0, 0, "R9");
    // R2 / R3: steady word, no interrupt
    step(1, 0, 0, 1, 0, 0, "R3");
    step(0, 1, 0, 1, 0, 0, "R6");
    step(0, 1, 0, 1, 0, 0, "R7");
    step(0, 1, 0, 1, 0, 0, "R7");
    step(0, 1, 0, 1, 0, 1, "R7");
    step(0, 1, 0, 1, 0, 0, "R7");
    step(0, 0, 1, 1, 0, 0, "R6");
    step(1, 0, 1, 1, 0, 1, "R8");
    step(1, 0, 1, 1, 0, 1, "R7");
    // R4: level drops, class lines go low, a change occurs
    step(1, 1, 1, 0, 0, 0, "R4");
    step(1, 1, 1, 0, 0, 1, "R7");
    // R10: class toggles under no level are ignored
    step(0, 1, 0, 0, 0, 0, "R10");
    step(1, 0, 1, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 0, "R10");
    // R5: force makes level present
    step(0, 1, 1, 0, 1, 0, "R5");
    step(0, 1, 1, 0, 1, 1, "R5");
    step(1, 0, 0, 0, 1, 1, "R5");
    step(0, 0, 0, 1, 0, 1, "R2");
    // mixed stretch
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom;
      step(r[0], r[1], r[2], r[3] & r[4], r[5] & r[6] & r[7], r[8] & r[9], "R3");
    end
    // R1 / R9 again mid-run
    rst = 1'b1;
    step(1, 1, 1, 1, 0, 0, "R1");
    rst = 1'b0;
    step(0, 1, 1, 0, 1, 0, "R9");
    step(0, 1, 1, 0, 1, 0, "R9");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200us;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule